// File: doc/BRIEF.md
# Automatic Retransmission Controller

This block is the retry engine on the transmit side of a packet radio baseband. When a packet is waiting, it issues a launch pulse to the link layer. It then waits for the link layer to report that the frame is on air. If acknowledgement is expected, it opens a waiting window whose length comes from a programmable delay code. An acknowledgement inside that window completes the packet. If the window expires instead, the engine relaunches the same packet, up to a programmable number of retries. After the last retry fails, it raises a sticky failure flag.

Two status flags are kept: packet delivered, and retry limit reached. Each flag is cleared by writing a one to it, and each can be kept off the active-low interrupt line by its own mask bit. A 4-bit counter of failed packets stops at its top value. While that counter is full, or while the failure flag is set, no new packet is launched. The failed-packet counter is cleared only by a write strobe to the channel register.

Top module: `retry_engine`

## Requirements
- R1: `retry_cfg[7:4]` is the delay code and `retry_cfg[3:0]` is the retry limit. Both are captured when a packet is launched, and later changes to `retry_cfg` do not affect that packet.
- R2: With acknowledgement enabled, `tx_fire` for a retransmission rises (code+1)*TICK_CYCLES clock edges after the edge that samples `tx_done`. Code 0 therefore gives 1 tick and code 15 gives 16 ticks.
- R3: A limit of 0 gives no retransmission. A limit of L gives exactly L retransmissions after the first launch, and then the packet ends with no further `tx_fire`.
- R4: `retry_cnt` reads 0 when a new packet is launched and increases by one with each retransmission.
- R5: An `ack_rx` pulse during the waiting window ends the packet on the next edge. It sets the delivered flag (`sts_sent`), cancels the pending retry, and returns `busy` low.
- R6: With `auto_ack_en` low when `tx_done` is sampled, the delivered flag is set on that edge and the engine goes idle without waiting.
- R7: When the retry limit is exhausted, `sts_maxrt` is set. While it is set, no packet is launched, even with `tx_req` high.
- R8: `lost_cnt` increases by one on each packet that ends in failure and saturates at 15. While it reads 15, no packet is launched. A `chan_wr` pulse clears it to 0.
- R9: Clear vector bit 0 is the delivered flag and bit 1 is the failure flag. Writing a 1 to a bit clears that flag on the next edge. If a set and a clear occur in the same cycle, the set wins.
- R10: `irq_n` is low exactly when a flag is set and its mask bit is 0. Mask bit 0 is the delivered flag and mask bit 1 is the failure flag.
- R11: During reset, `tx_fire`, `busy`, both flags, `retry_cnt` and `lost_cnt` are 0, and `irq_n` is 1.
- R12: `ack_rx` outside the waiting window, whether the engine is idle or the frame is still on air, has no effect on the flags or the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retry_cfg | input | 8 | Delay code (upper nibble) and retry limit (lower nibble) |
| auto_ack_en | input | 1 | Acknowledgement expected for the current frame |
| tx_req | input | 1 | A packet is waiting to be sent |
| tx_done | input | 1 | Link layer: frame finished on air (pulse) |
| ack_rx | input | 1 | Link layer: acknowledgement received (pulse) |
| chan_wr | input | 1 | Channel register write strobe; clears the lost counter |
| clr_flags | input | 2 | Write-one-to-clear strobes: bit 0 delivered, bit 1 failure |
| irq_mask | input | 2 | Interrupt masks: bit 0 delivered, bit 1 failure |
| tx_fire | output | 1 | One-cycle launch pulse to the link layer |
| busy | output | 1 | A packet sequence is in progress |
| sts_sent | output | 1 | Delivered flag |
| sts_maxrt | output | 1 | Retry limit reached flag |
| retry_cnt | output | 4 | Retransmissions of the current packet |
| lost_cnt | output | 4 | Saturating count of failed packets |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the engine with TICK_CYCLES set to 3, so the 250 µs tick shrinks to three clocks. At that size, every delay code from 1 to 16 ticks and the full 15-retry limit fit in a short run. This lets the random packets measure the exact launch-to-launch distance for any configuration byte. The lost counter keeps its default 4-bit width, so fifteen quick limit-0 failures bring saturation, the launch block and its release by a channel write within reach.

// File: rtl/arc_pkg.sv
package arc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_AIR  = 2'd1,
        ST_WAIT = 2'd2
    } arc_state_e;

    localparam int FLAG_SENT  = 0;
    localparam int FLAG_MAXRT = 1;
    localparam int NUM_FLAGS  = 2;
endpackage

// File: rtl/arc_delay_timer.sv
module arc_delay_timer #(
    parameter int TICK_CYCLES = 25000,
    parameter int CODE_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [CODE_W-1:0] code,
    output logic              expire
);
    localparam int PRESC_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(TICK_CYCLES - 1);

    typedef struct packed {
        logic              run;
        logic [PRESC_W-1:0] presc;
        logic [CODE_W-1:0]  ticks;
    } tmr_t;

    tmr_t r_d, r_q;
    logic tick_end;

    assign tick_end = (r_q.presc == PRESC_LAST);
    assign expire   = r_q.run && tick_end && (r_q.ticks == code);

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.run   = 1'b1;
            r_d.presc = '0;
            r_d.ticks = '0;
        end else if (abort) begin
            r_d.run = 1'b0;
        end else if (r_q.run) begin
            if (tick_end) begin
                r_d.presc = '0;
                if (r_q.ticks == code) begin
                    r_d.run = 1'b0;
                end else begin
                    r_d.ticks = r_q.ticks + 1'b1;
                end
            end else begin
                r_d.presc = r_q.presc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R2: the tick count never passes the programmed code
    p_ticks_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.run |-> (r_q.ticks <= code));

    // R2: a window expires once and then the timer is idle
    p_expire_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start) |=> !r_q.run);
endmodule

// File: rtl/arc_sat_counter.sv
module arc_sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         full
);
    logic [W-1:0] cnt_d, cnt_q;

    assign full = &cnt_q;
    assign cnt  = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && !full) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R8: a full counter holds until cleared, it never wraps
    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> full);

    // R8: a clear always reaches zero
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/arc_status_flags.sv
module arc_status_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flags,
    output logic         irq_n
);
    logic [N-1:0] flags_d, flags_q;

    assign flags = flags_q;
    assign irq_n = ~|(flags_q & ~mask);

    always_comb begin
        flags_d = (flags_q & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R9: write-one clears a flag when no set competes
        p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !flags_q[i]);
        // R9: a set event is never lost, even against a clear
        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags_q[i]);
    end
endmodule

// File: rtl/retry_engine.sv
module retry_engine
    import arc_pkg::*;
#(
    parameter int TICK_CYCLES = 25000,
    parameter int CODE_W      = 4,
    parameter int LOST_W      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*CODE_W-1:0] retry_cfg,
    input  logic                auto_ack_en,
    input  logic                tx_req,
    input  logic                tx_done,
    input  logic                ack_rx,
    input  logic                chan_wr,
    input  logic [1:0]          clr_flags,
    input  logic [1:0]          irq_mask,
    output logic                tx_fire,
    output logic                busy,
    output logic                sts_sent,
    output logic                sts_maxrt,
    output logic [CODE_W-1:0]   retry_cnt,
    output logic [LOST_W-1:0]   lost_cnt,
    output logic                irq_n
);
    localparam int CFG_W = 2 * CODE_W;

    typedef struct packed {
        arc_state_e        state;
        logic              fire;
        logic [CODE_W-1:0] limit;
        logic [CODE_W-1:0] code;
    } eng_t;

    eng_t st_d, st_q;

    logic                 launch;
    logic                 tmr_start, tmr_abort, tmr_expire;
    logic                 lost_inc, lost_full;
    logic                 rtr_clr, rtr_inc, rtr_full;
    logic [NUM_FLAGS-1:0] set_vec, flags;

    assign launch = (st_q.state == ST_IDLE) && tx_req && !flags[FLAG_MAXRT] && !lost_full;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        tmr_start = 1'b0;
        tmr_abort = 1'b0;
        set_vec   = '0;
        lost_inc  = 1'b0;
        rtr_clr   = 1'b0;
        rtr_inc   = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (launch) begin
                    st_d.fire  = 1'b1;
                    st_d.limit = retry_cfg[CODE_W-1:0];
                    st_d.code  = retry_cfg[CFG_W-1:CODE_W];
                    st_d.state = ST_AIR;
                    rtr_clr    = 1'b1;
                end
            end
            ST_AIR: begin
                if (tx_done) begin
                    if (auto_ack_en) begin
                        tmr_start  = 1'b1;
                        st_d.state = ST_WAIT;
                    end else begin
                        set_vec[FLAG_SENT] = 1'b1;
                        st_d.state         = ST_IDLE;
                    end
                end
            end
            ST_WAIT: begin
                if (ack_rx) begin
                    tmr_abort          = 1'b1;
                    set_vec[FLAG_SENT] = 1'b1;
                    st_d.state         = ST_IDLE;
                end else if (tmr_expire) begin
                    if (retry_cnt == st_q.limit) begin
                        set_vec[FLAG_MAXRT] = 1'b1;
                        lost_inc            = 1'b1;
                        st_d.state          = ST_IDLE;
                    end else begin
                        st_d.fire  = 1'b1;
                        rtr_inc    = 1'b1;
                        st_d.state = ST_AIR;
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, fire: 1'b0, limit: '0, code: '0};
        end else begin
            st_q <= st_d;
        end
    end

    arc_delay_timer #(.TICK_CYCLES(TICK_CYCLES), .CODE_W(CODE_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .abort  (tmr_abort),
        .code   (st_q.code),
        .expire (tmr_expire)
    );

    arc_sat_counter #(.W(CODE_W)) u_retry_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rtr_clr),
        .inc   (rtr_inc),
        .cnt   (retry_cnt),
        .full  (rtr_full)
    );

    arc_sat_counter #(.W(LOST_W)) u_lost_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (chan_wr),
        .inc   (lost_inc),
        .cnt   (lost_cnt),
        .full  (lost_full)
    );

    arc_status_flags #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_vec),
        .clr   (clr_flags),
        .mask  (irq_mask),
        .flags (flags),
        .irq_n (irq_n)
    );

    assign tx_fire   = st_q.fire;
    assign busy      = (st_q.state != ST_IDLE);
    assign sts_sent  = flags[FLAG_SENT];
    assign sts_maxrt = flags[FLAG_MAXRT];

    // R2: each launch is a single-cycle pulse
    p_fire_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire |=> !tx_fire);

    // R3: retransmissions never exceed the captured limit
    p_retry_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (retry_cnt <= st_q.limit));

    // R3: the retry counter is never driven into saturation
    p_retry_no_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rtr_full |-> (st_q.limit == '1));

    // R5: an acknowledgement in the window ends the packet at once
    p_ack_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_WAIT && ack_rx) |=> (!busy && sts_sent && !tx_fire));

    // R7: a pending failure flag blocks every launch
    p_maxrt_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sts_maxrt) |=> !tx_fire);

    // R8: a full lost counter blocks every launch
    p_lost_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && lost_full) |=> !tx_fire);

    // R12: ack outside the window leaves the delivered flag alone
    p_ack_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state != ST_WAIT && !tx_done && ack_rx && !sts_sent) |=> !sts_sent);
endmodule

// File: tb/tb_retry_engine.sv
module tb_retry_engine;
    localparam int TICK = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] retry_cfg = '0;
    logic       auto_ack_en = 1'b0;
    logic       tx_req = 1'b0;
    logic       tx_done = 1'b0;
    logic       ack_rx = 1'b0;
    logic       chan_wr = 1'b0;
    logic [1:0] clr_flags = '0;
    logic [1:0] irq_mask = '0;
    logic       tx_fire, busy, sts_sent, sts_maxrt, irq_n;
    logic [3:0] retry_cnt, lost_cnt;

    int checks = 0;
    int fails = 0;
    int lost_exp = 0;
    bit exp_sent = 0;
    bit exp_maxrt = 0;

    always #5 clk = ~clk;

    retry_engine #(.TICK_CYCLES(TICK), .CODE_W(4), .LOST_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .retry_cfg(retry_cfg), .auto_ack_en(auto_ack_en),
        .tx_req(tx_req), .tx_done(tx_done), .ack_rx(ack_rx), .chan_wr(chan_wr),
        .clr_flags(clr_flags), .irq_mask(irq_mask), .tx_fire(tx_fire), .busy(busy),
        .sts_sent(sts_sent), .sts_maxrt(sts_maxrt), .retry_cnt(retry_cnt),
        .lost_cnt(lost_cnt), .irq_n(irq_n)
    );

    function automatic int exp_delay(input int code);
        return (code + 1) * TICK;
    endfunction

    function automatic int exp_irq_n(input bit s, input bit m, input logic [1:0] msk);
        return ((s && !msk[0]) || (m && !msk[1])) ? 0 : 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_clr(input logic [1:0] v);
        @(negedge clk); clr_flags = v;
        @(negedge clk); clr_flags = '0;
        if (v[0]) exp_sent = 0;
        if (v[1]) exp_maxrt = 0;
    endtask

    task automatic watch_no_fire(input int cyc, input string req);
        bit seen = 0;
        for (int k = 0; k < cyc; k++) begin
            @(posedge clk); #1;
            if (tx_fire) seen = 1;
        end
        chk(req, seen, 0);
    endtask

    task automatic do_packet(input logic [7:0] cfg, input int ack_at, input bit aa);
        int code, lim, n;
        bit seen;
        code = int'(cfg[7:4]);
        lim  = int'(cfg[3:0]);
        @(negedge clk); retry_cfg = cfg; auto_ack_en = aa; tx_req = 1'b1;
        seen = 0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); #1;
            if (tx_fire) begin seen = 1; break; end
        end
        chk("R1 launch", seen, 1);
        @(negedge clk); tx_req = 1'b0; retry_cfg = ~cfg;
        if (!seen) return;
        for (int a = 0; a <= lim; a++) begin
            chk("R4 retry_cnt", retry_cnt, a);
            @(negedge clk); tx_done = 1'b1;
            @(negedge clk); tx_done = 1'b0;
            if (!aa) begin
                chk("R6 sent", sts_sent, 1);
                chk("R6 idle", busy, 0);
                exp_sent = 1;
                return;
            end
            if (a == ack_at) begin
                ack_rx = 1'b1;
                @(negedge clk); ack_rx = 1'b0;
                chk("R5 sent", sts_sent, 1);
                chk("R5 idle", busy, 0);
                exp_sent = 1;
                watch_no_fire(exp_delay(code) + 4, "R5 cancel");
                return;
            end
            n = 0;
            do begin
                @(posedge clk); #1; n++;
            end while (!tx_fire && busy && n < 300);
            chk("R1 R2 delay", n, exp_delay(code));
            if (a == lim) begin
                chk("R3 stop", busy, 0);
                chk("R3 no fire", tx_fire, 0);
                chk("R7 maxrt", sts_maxrt, 1);
                if (lost_exp < 15) lost_exp++;
                chk("R8 lost", lost_cnt, lost_exp);
                exp_maxrt = 1;
            end else begin
                chk("R3 retry fire", tx_fire, 1);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog act=150000 exp=less");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11 fire", tx_fire, 0);
        chk("R11 busy", busy, 0);
        chk("R11 sent", sts_sent, 0);
        chk("R11 maxrt", sts_maxrt, 0);
        chk("R11 retry", retry_cnt, 0);
        chk("R11 lost", lost_cnt, 0);
        chk("R11 irq", irq_n, 1);
        @(negedge clk); rst_n = 1'b1;

        // R12 ack while idle
        @(negedge clk); ack_rx = 1'b1;
        @(negedge clk); ack_rx = 1'b0;
        chk("R12 idle ack", sts_sent, 0);
        chk("R12 idle busy", busy, 0);

        // R3 limit zero, R12 ack while on air
        @(negedge clk); retry_cfg = 8'h00; auto_ack_en = 1'b1; tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        chk("R1 launch direct", busy, 1);
        ack_rx = 1'b1;
        @(negedge clk); ack_rx = 1'b0;
        chk("R12 air ack", sts_sent, 0);
        tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
        repeat (TICK + 2) @(negedge clk);
        chk("R3 limit0 end", busy, 0);
        chk("R7 maxrt set", sts_maxrt, 1);
        lost_exp = 1;
        exp_maxrt = 1;
        chk("R8 lost one", lost_cnt, 1);

        // R10 masking, R7 blocking
        irq_mask = 2'b00; #1;
        chk("R10 irq unmasked", irq_n, 0);
        irq_mask = 2'b10; #1;
        chk("R10 irq masked", irq_n, 1);
        irq_mask = 2'b00;
        @(negedge clk); tx_req = 1'b1;
        watch_no_fire(20, "R7 blocked");
        @(negedge clk); tx_req = 1'b0;
        pulse_clr(2'b10);
        chk("R9 clear maxrt", sts_maxrt, 0);
        chk("R10 irq idle", irq_n, 1);

        // R6 no-ack completion with a competing clear: R9 set wins
        @(negedge clk); retry_cfg = 8'h33; auto_ack_en = 1'b0; tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        tx_done = 1'b1; clr_flags = 2'b01;
        @(negedge clk); tx_done = 1'b0; clr_flags = 2'b00;
        chk("R9 set wins", sts_sent, 1);
        chk("R6 idle", busy, 0);
        irq_mask = 2'b01; #1;
        chk("R10 sent masked", irq_n, 1);
        irq_mask = 2'b00; #1;
        chk("R10 sent unmasked", irq_n, 0);
        pulse_clr(2'b01);
        chk("R9 clear sent", sts_sent, 0);

        // R8 saturation and release
        while (lost_exp < 15) begin
            do_packet(8'h00, 99, 1'b1);
            pulse_clr(2'b11);
        end
        chk("R8 lost full", lost_cnt, 15);
        @(negedge clk); tx_req = 1'b1;
        watch_no_fire(20, "R8 blocked");
        @(negedge clk); tx_req = 1'b0;
        chk("R8 lost held", lost_cnt, 15);
        @(negedge clk); chan_wr = 1'b1;
        @(negedge clk); chan_wr = 1'b0;
        lost_exp = 0;
        chk("R8 chan clear", lost_cnt, 0);
        do_packet(8'h21, 1, 1'b1);
        pulse_clr(2'b11);

        // directed extremes of delay and limit
        do_packet(8'hF2, 99, 1'b1);
        pulse_clr(2'b11);
        do_packet(8'h1F, 99, 1'b1);
        pulse_clr(2'b11);

        // random packets
        for (int p = 0; p < 24; p++) begin
            logic [7:0] cfg;
            logic [1:0] msk;
            int ack_at;
            bit aa;
            cfg = 8'($urandom);
            ack_at = $urandom_range(0, int'(cfg[3:0]) + 1);
            aa = ($urandom_range(0, 5) != 0);
            if (lost_exp == 15) begin
                @(negedge clk); chan_wr = 1'b1;
                @(negedge clk); chan_wr = 1'b0;
                lost_exp = 0;
            end
            do_packet(cfg, ack_at, aa);
            msk = 2'($urandom);
            @(negedge clk); irq_mask = msk; #1;
            chk("R10 random irq", irq_n, exp_irq_n(exp_sent, exp_maxrt, msk));
            pulse_clr(2'b11);
            chk("R9 random clear", int'({sts_maxrt, sts_sent}), 0);
        end

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule